// File: doc/BRIEF.md
# Dual-Clock Mailbox Bypass Registers

This block carries command words between two independently clocked ports without going through a queue. It has two mail slots. The first slot is loaded from port A and read at port B. The second slot is loaded from port B and read at port A. Each slot has an active-low full flag. The flag falls when the writing port deposits a word. It rises again after the opposite port has taken a read from that slot. Until the flag rises, further deposits into the slot are refused.

Each port has a clock, an active-low chip select, a write/read select, an enable and a mailbox select. A port access happens only when chip select is LOW and enable is HIGH. The write/read select then gives the direction, and mailbox select picks between the mail slot and the FIFO path. Each port also drives a data-out mux. With mailbox select HIGH it shows the slot that the port reads; otherwise it passes the FIFO output register word, which arrives on a separate input.

Each full flag lives in the domain of the port that writes the slot. A read at the other port flips a toggle register in the reader's domain. A chain of flip-flops in the writer's domain carries that toggle across, and an edge on it clears the flag. Reset drives both flags HIGH (empty) and clears both slots.

Top module: `mbx_bypass`

## Requirements
- R1: While reset is asserted, and after it is released, both full flags read HIGH and both slots hold zero. Asserting reset drives the flags HIGH without waiting for a clock edge.
- R2: A port does nothing at its clock edge unless chip select is LOW and enable is HIGH. A HIGH write/read select means write, and LOW means read.
- R3: A port-A write with mailbox select HIGH loads din_a into slot 1 at the rising clk_a edge. mail1_full_n is LOW after that edge.
- R4: A port-B write with mailbox select HIGH loads din_b into slot 2 at the rising clk_b edge. mail2_full_n is LOW after that edge.
- R5: A write into a slot whose full flag is LOW is ignored. The stored word and the flag both stay as they were.
- R6: A port-B read with mailbox select HIGH makes mail1_full_n HIGH. The flag is still LOW after the first and second rising clk_a edges following the read edge, and it is HIGH after the third.
- R7: A port-A read with mailbox select HIGH makes mail2_full_n HIGH. The flag is still LOW after the first and second rising clk_b edges following the read edge, and it is HIGH after the third.
- R8: dout_a shows slot 2 when mbx_a is HIGH and fifo_q_a when it is LOW. dout_b shows slot 1 when mbx_b is HIGH and fifo_q_b when it is LOW. This mux is combinational and does not depend on chip select or enable.
- R9: Reading a slot leaves its contents unchanged, so repeated reads return the same word.
- R10: Once a flag has returned HIGH, the next write into that slot is accepted and loads the new word.
- R11: An access with mailbox select LOW changes neither slot nor either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain |
| cs_a_n | input | 1 | Port A chip select, active low |
| wr_a | input | 1 | Port A direction, 1 = write, 0 = read |
| en_a | input | 1 | Port A enable |
| mbx_a | input | 1 | Port A mailbox select |
| din_a | input | 36 | Port A write data |
| fifo_q_a | input | 36 | FIFO output register word for port A |
| dout_a | output | 36 | Port A read data |
| mail1_full_n | output | 1 | Slot 1 full flag, active low, clk_a domain |
| cs_b_n | input | 1 | Port B chip select, active low |
| wr_b | input | 1 | Port B direction, 1 = write, 0 = read |
| en_b | input | 1 | Port B enable |
| mbx_b | input | 1 | Port B mailbox select |
| din_b | input | 36 | Port B write data |
| fifo_q_b | input | 36 | FIFO output register word for port B |
| dout_b | output | 36 | Port B read data |
| mail2_full_n | output | 1 | Slot 2 full flag, active low, clk_b domain |

## Verification
The results of this block become visible at three different times. A write shows in the stored word and the writer's flag one writer-clock edge later, so the bench drives on a falling edge and samples at the next falling edge. The flag release that a read causes needs the third writer-clock edge after the read edge. The bench waits for the read edge, then samples 1 ns after each of the next three writer-clock edges and expects LOW, LOW and then HIGH. The clocks are phased so that their edges never coincide, which fixes that count. The data mux and the reset assertion have no clock stage, so they are checked 1 ns after the stimulus changes.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Port access kinds after decoding the strobes
  typedef enum logic [1:0] {
    ACC_IDLE    = 2'd0,
    ACC_MAIL_WR = 2'd1,
    ACC_MAIL_RD = 2'd2,
    ACC_FIFO    = 2'd3
  } acc_e;

  function automatic acc_e decode_access(input logic cs_n, input logic wr,
                                         input logic en, input logic mbx);
    if (cs_n || !en) return ACC_IDLE;
    if (!mbx)        return ACC_FIFO;
    return wr ? ACC_MAIL_WR : ACC_MAIL_RD;
  endfunction

endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/mbx_tgl_sync.sv
module mbx_tgl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_i,
  output logic pulse_o
);
  // STAGES synchronizing flops plus one history flop for edge detection
  logic [STAGES:0] sync_q;
  logic [STAGES:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-1:0], tgl_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign pulse_o = sync_q[STAGES] ^ sync_q[STAGES-1];
endmodule

// File: rtl/mbx_evt_src.sv
module mbx_evt_src (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_i,
  output logic tgl_o
);
  logic tgl_q;
  logic tgl_d;

  always_comb tgl_d = rd_i ? ~tgl_q : tgl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgl_q <= 1'b0;
    else        tgl_q <= tgl_d;
  end

  assign tgl_o = tgl_q;

  // R6 R7
  tgl_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgl_q != $past(tgl_q)) |-> $past(rd_i));
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  input  logic          clr_i,
  output logic [DW-1:0] data_o,
  output logic          full_n_o
);
  logic          full_q;
  logic          full_d;
  logic [DW-1:0] data_q;
  logic          load;

  always_comb begin
    load   = wr_i && !full_q;
    full_d = full_q;
    if (clr_i) full_d = 1'b0;
    if (load)  full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (load) data_q <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  assign data_o   = data_q;
  assign full_n_o = ~full_q;

  // R3 R4
  accept_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !full_q) |=> (full_q && data_q == $past(data_i)));

  // R5
  locked_write_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && full_q && !clr_i) |=> full_q);

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && !full_q) |=> $stable(data_q));

  // R6 R7
  release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full_q) |-> $past(clr_i));
endmodule

// File: rtl/mbx_bypass.sv
module mbx_bypass
  import mbx_pkg::*;
#(
  parameter int DW          = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_a,
  input  logic          clk_b,
  input  logic          rst_n,
  input  logic          cs_a_n,
  input  logic          wr_a,
  input  logic          en_a,
  input  logic          mbx_a,
  input  logic [DW-1:0] din_a,
  input  logic [DW-1:0] fifo_q_a,
  output logic [DW-1:0] dout_a,
  output logic          mail1_full_n,
  input  logic          cs_b_n,
  input  logic          wr_b,
  input  logic          en_b,
  input  logic          mbx_b,
  input  logic [DW-1:0] din_b,
  input  logic [DW-1:0] fifo_q_b,
  output logic [DW-1:0] dout_b,
  output logic          mail2_full_n
);
  localparam int NCH = 2;  // channel 0: A->B (slot 1), channel 1: B->A (slot 2)

  logic          clk_dom  [NCH];
  logic          rst_dom  [NCH];
  logic          wr_req   [NCH];
  logic          rd_req   [NCH];
  logic [DW-1:0] wdata    [NCH];
  logic [DW-1:0] slot_q   [NCH];
  logic          slot_fn  [NCH];
  logic          rd_tgl   [NCH];
  logic          clr_pls  [NCH];
  acc_e          acc_a;
  acc_e          acc_b;

  assign clk_dom[0] = clk_a;
  assign clk_dom[1] = clk_b;

  always_comb begin
    acc_a = decode_access(cs_a_n, wr_a, en_a, mbx_a);
    acc_b = decode_access(cs_b_n, wr_b, en_b, mbx_b);
  end

  // writer-side requests indexed by channel; reader of channel c is domain 1-c
  assign wr_req[0] = (acc_a == ACC_MAIL_WR);
  assign wr_req[1] = (acc_b == ACC_MAIL_WR);
  assign rd_req[0] = (acc_b == ACC_MAIL_RD);
  assign rd_req[1] = (acc_a == ACC_MAIL_RD);
  assign wdata[0]  = din_a;
  assign wdata[1]  = din_b;

  for (genvar d = 0; d < NCH; d++) begin : g_rst
    mbx_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
      .clk     (clk_dom[d]),
      .arst_n  (rst_n),
      .rst_n_o (rst_dom[d])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int WD = c;
    localparam int RD = NCH - 1 - c;

    mbx_evt_src u_evt (
      .clk   (clk_dom[RD]),
      .rst_n (rst_dom[RD]),
      .rd_i  (rd_req[c]),
      .tgl_o (rd_tgl[c])
    );

    mbx_tgl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk_dom[WD]),
      .rst_n   (rst_dom[WD]),
      .tgl_i   (rd_tgl[c]),
      .pulse_o (clr_pls[c])
    );

    mbx_slot #(.DW(DW)) u_slot (
      .clk      (clk_dom[WD]),
      .rst_n    (rst_dom[WD]),
      .wr_i     (wr_req[c]),
      .data_i   (wdata[c]),
      .clr_i    (clr_pls[c]),
      .data_o   (slot_q[c]),
      .full_n_o (slot_fn[c])
    );
  end

  assign dout_a       = mbx_a ? slot_q[1] : fifo_q_a;
  assign dout_b       = mbx_b ? slot_q[0] : fifo_q_b;
  assign mail1_full_n = slot_fn[0];
  assign mail2_full_n = slot_fn[1];
endmodule

// File: tb/tb_mbx_bypass.sv
module tb_mbx_bypass;
  localparam int DW = 36;
  localparam logic [DW-1:0] D1  = 36'h9_1234_5678;
  localparam logic [DW-1:0] D2  = 36'hA_BCDE_F012;
  localparam logic [DW-1:0] D3  = 36'h3_0C0C_A5A5;
  localparam logic [DW-1:0] D4  = 36'h5_5555_0001;
  localparam logic [DW-1:0] FQA = 36'hF_0F0F_0F0F;
  localparam logic [DW-1:0] FQB = 36'h0_F0F0_F0F0;
  localparam int NV = 6;

  // {cs_n, wr, en, mbx, din[35:0], exp_full_n, exp_slot1[35:0]}
  localparam logic [76:0] VECS [NV] = '{
    {4'b1111, D2, 1'b1, 36'h0},  // R2 chip select high: ignored
    {4'b0101, D2, 1'b1, 36'h0},  // R2 enable low: ignored
    {4'b0110, D2, 1'b1, 36'h0},  // R11 mailbox select low: FIFO path
    {4'b0011, D2, 1'b1, 36'h0},  // R2 read direction: no load
    {4'b0111, D1, 1'b0, D1},     // R3 accepted write
    {4'b0111, D2, 1'b0, D1}      // R5 write while full: ignored
  };

  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic cs_a_n, wr_a, en_a, mbx_a, cs_b_n, wr_b, en_b, mbx_b;
  logic [DW-1:0] din_a, din_b, fifo_q_a, fifo_q_b, dout_a, dout_b;
  logic mail1_full_n, mail2_full_n;
  int checks = 0, failures = 0;

  always #4 clk_a = ~clk_a;                    // 125 MHz
  initial begin #3; forever #6 clk_b = ~clk_b; end

  mbx_bypass dut (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .cs_a_n(cs_a_n), .wr_a(wr_a), .en_a(en_a), .mbx_a(mbx_a),
    .din_a(din_a), .fifo_q_a(fifo_q_a), .dout_a(dout_a), .mail1_full_n(mail1_full_n),
    .cs_b_n(cs_b_n), .wr_b(wr_b), .en_b(en_b), .mbx_b(mbx_b),
    .din_b(din_b), .fifo_q_b(fifo_q_b), .dout_b(dout_b), .mail2_full_n(mail2_full_n)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic a_idle();
    cs_a_n = 1'b1; wr_a = 1'b0; en_a = 1'b0; mbx_a = 1'b1;
  endtask

  task automatic b_idle();
    cs_b_n = 1'b1; wr_b = 1'b0; en_b = 1'b0; mbx_b = 1'b1;
  endtask

  task automatic a_op(input logic cs_n, input logic wr, input logic en,
                      input logic mbx, input logic [DW-1:0] d);
    @(negedge clk_a);
    cs_a_n = cs_n; wr_a = wr; en_a = en; mbx_a = mbx; din_a = d;
    @(negedge clk_a);
    a_idle();
    #1;
  endtask

  task automatic b_op(input logic cs_n, input logic wr, input logic en,
                      input logic mbx, input logic [DW-1:0] d);
    @(negedge clk_b);
    cs_b_n = cs_n; wr_b = wr; en_b = en; mbx_b = mbx; din_b = d;
    @(negedge clk_b);
    b_idle();
    #1;
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    a_idle(); b_idle();
    din_a = '0; din_b = '0; fifo_q_a = FQA; fifo_q_b = FQB;
    #1;
    chk("R1 slot1 flag in reset", {35'h0, mail1_full_n}, 36'h1);
    chk("R1 slot2 flag in reset", {35'h0, mail2_full_n}, 36'h1);
    #30 rst_n = 1'b1;
    repeat (5) @(negedge clk_b);
    #1;
    chk("R1 slot1 flag after reset", {35'h0, mail1_full_n}, 36'h1);
    chk("R1 slot2 flag after reset", {35'h0, mail2_full_n}, 36'h1);
    chk("R1 slot1 zero", dout_b, 36'h0);
    chk("R1 slot2 zero", dout_a, 36'h0);
    mbx_a = 1'b0; mbx_b = 1'b0; #1;
    chk("R8 port A fifo path", dout_a, FQA);
    chk("R8 port B fifo path", dout_b, FQB);
    mbx_a = 1'b1; mbx_b = 1'b1; #1;

    for (int i = 0; i < NV; i++) begin
      a_op(VECS[i][76], VECS[i][75], VECS[i][74], VECS[i][73], VECS[i][72:37]);
      chk($sformatf("R2/R3/R5/R11 vec%0d flag", i), {35'h0, mail1_full_n}, {35'h0, VECS[i][36]});
      chk($sformatf("R2/R3/R5/R11 vec%0d slot1", i), dout_b, VECS[i][35:0]);
    end

    // R6 R9: port B reads slot 1, flag returns HIGH on third clk_a edge
    @(negedge clk_b);
    cs_b_n = 1'b0; wr_b = 1'b0; en_b = 1'b1; mbx_b = 1'b1;
    @(posedge clk_b);
    #1;
    b_idle();
    chk("R9 read data slot1", dout_b, D1);
    @(posedge clk_a); #1;
    chk("R6 flag low after edge1", {35'h0, mail1_full_n}, 36'h0);
    @(posedge clk_a); #1;
    chk("R6 flag low after edge2", {35'h0, mail1_full_n}, 36'h0);
    @(posedge clk_a); #1;
    chk("R6 flag high after edge3", {35'h0, mail1_full_n}, 36'h1);
    chk("R9 slot1 intact after read", dout_b, D1);

    // R10: new write accepted after release
    a_op(1'b0, 1'b1, 1'b1, 1'b1, D3);
    chk("R10 flag low after rewrite", {35'h0, mail1_full_n}, 36'h0);
    chk("R10 slot1 new word", dout_b, D3);

    // R4 R5: port B fills slot 2, second write locked out
    b_op(1'b0, 1'b1, 1'b1, 1'b1, D4);
    chk("R4 slot2 flag low", {35'h0, mail2_full_n}, 36'h0);
    chk("R4 slot2 data", dout_a, D4);
    b_op(1'b0, 1'b1, 1'b1, 1'b1, D2);
    chk("R5 slot2 locked data", dout_a, D4);
    chk("R5 slot2 locked flag", {35'h0, mail2_full_n}, 36'h0);

    // R7: port A read releases slot 2 on third clk_b edge
    @(negedge clk_a);
    cs_a_n = 1'b0; wr_a = 1'b0; en_a = 1'b1; mbx_a = 1'b1;
    @(posedge clk_a);
    #1;
    a_idle();
    @(posedge clk_b); #1;
    chk("R7 flag low after edge1", {35'h0, mail2_full_n}, 36'h0);
    @(posedge clk_b); #1;
    chk("R7 flag low after edge2", {35'h0, mail2_full_n}, 36'h0);
    @(posedge clk_b); #1;
    chk("R7 flag high after edge3", {35'h0, mail2_full_n}, 36'h1);
    chk("R9 slot2 intact after read", dout_a, D4);

    // R11: port B read with mailbox select low leaves slot 1 full
    b_op(1'b0, 1'b0, 1'b1, 1'b0, D2);
    repeat (6) @(posedge clk_a);
    #1;
    chk("R11 slot1 flag unchanged", {35'h0, mail1_full_n}, 36'h0);
    chk("R11 slot1 data unchanged", dout_b, D3);
    mbx_b = 1'b0; #1;
    chk("R8 port B mux low", dout_b, FQB);
    mbx_b = 1'b1; #1;

    // R1: asynchronous reset assertion mid-run
    @(negedge clk_a); #2;
    rst_n = 1'b0; #1;
    chk("R1 async reset slot1 flag", {35'h0, mail1_full_n}, 36'h1);
    chk("R1 async reset slot1 data", dout_b, 36'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule